// File: doc/BRIEF.md
# Time Slot Interchanger with Per-Slot Delay Modes

This block moves bytes between time slots of several framed streams. Every cycle is one slot time. In each slot the byte arriving on each receive stream is stored in a data memory. For each outgoing slot, the block reads a connection entry through a read port. The entry names a source stream, a source slot and a delay mode, and the selected byte is driven on that output stream in that slot. A frame pulse marks slot 0. The block keeps its own slot count and reports it.

The data memory holds three frame banks that rotate at every frame start. In latency mode an output slot takes the newest copy of its source slot that is at least three slot times old. In integrity mode an output slot always takes the copy stored two frames before, so every byte of a frame leaves in the same later frame. Each output slot of each stream picks its mode on its own.

Delay is counted in slot times, from the slot in which a byte is on `rx_data` to the slot in which it is on `tx_data`. Below, s is the source slot and t is the destination slot, both as plain integers from 0 to NUM_SLOTS-1, and the source byte arrives in frame p.

Top module: `tsi_switch`

## Requirements
- R1: `slot_o` is 0 in any cycle with `frame_pulse` high. In every other cycle it is the previous value plus one, wrapping from NUM_SLOTS-1 to 0.
- R2: In latency mode (entry bit [SLOT_W+STRM_W] = 0), if t >= s+3 the byte leaves in slot t of frame p, so the delay is t-s.
- R3: In latency mode, if t < s+3 and t+NUM_SLOTS >= s+3, the byte leaves in slot t of frame p+1.
- R4: In latency mode, if t+NUM_SLOTS < s+3, the byte leaves in slot t of frame p+2. The latency-mode delay is therefore never below three slot times.
- R5: In integrity mode (entry bit [SLOT_W+STRM_W] = 1), the byte leaves in slot t of frame p+2. The delay is 2*NUM_SLOTS+t-s, which ranges from NUM_SLOTS+1 to 3*NUM_SLOTS-1.
- R6: Each output slot of each stream applies its own entry's mode, so integrity and latency slots can be mixed in one frame.
- R7: The source stream is entry bits [SLOT_W +: STRM_W] and the source slot is entry bits [SLOT_W-1:0]. The delay depends only on the slot numbers, and is the same for any source and destination stream.
- R8: While `rst` is high, `tx_data` is zero and `slot_o` is 0. Every stored byte reads as zero until the first byte is written to it.
- R9: `cm_slot` is always `slot_o`+1 modulo NUM_SLOTS. The entries on `cm_entry` in a cycle decide the bytes that `tx_data` shows in the next cycle.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Slot clock, one cycle per slot |
| rst | input | 1 | Synchronous active-high reset |
| frame_pulse | input | 1 | High in the cycle that is slot 0 of a frame |
| rx_data | input | NUM_STREAMS*DATA_W | Received byte of each stream in the current slot; stream i is at [i*DATA_W +: DATA_W] |
| slot_o | output | SLOT_W | Current slot number |
| cm_slot | output | SLOT_W | Output slot whose connection entries are requested this cycle |
| cm_entry | input | NUM_STREAMS*ENTRY_W | Connection entry of each output stream for `cm_slot` |
| tx_data | output | NUM_STREAMS*DATA_W | Transmitted byte of each stream in the current slot |

## Verification
Each received byte carries a tag made of its arrival time and its stream, so the expected output pins down the exact frame and slot of every byte. One set of phases shifts the source slot by every offset from 0 to NUM_SLOTS-1 with the stream crossed, once in latency mode and once in integrity mode. Together these cover every source and destination pair and separate the same-frame, next-frame and two-frames-later cases. Mixed phases alternate the mode from slot to slot, and same-stream phases show that the stream choice leaves the delay unchanged. The first frames after reset must return zero, which shows that the banks were cleared.

// File: rtl/tsi_pkg.sv
package tsi_pkg;

    localparam int N_BANKS = 3;

    // How many frames back the read bank lies behind the output frame's bank
    typedef enum logic [1:0] {
        AGE_SAME = 2'd0,
        AGE_ONE  = 2'd1,
        AGE_TWO  = 2'd2
    } age_e;

    function automatic logic [1:0] bank_next(input logic [1:0] b);
        return (b == 2'd2) ? 2'd0 : b + 2'd1;
    endfunction

    function automatic logic [1:0] bank_back(input logic [1:0] b, input age_e a);
        logic [2:0] t;
        t = {1'b0, b} + 3'd3 - {1'b0, a};
        if (t >= 3'd3) t = t - 3'd3;
        return t[1:0];
    endfunction

endpackage

// File: rtl/tsi_timebase.sv
module tsi_timebase
    import tsi_pkg::*;
#(
    parameter int NUM_SLOTS = 32,
    localparam int SLOT_W = $clog2(NUM_SLOTS)
) (
    input  logic              clk,
    input  logic              rst,
    input  logic              frame_pulse,
    output logic [SLOT_W-1:0] cur_slot,
    output logic [1:0]        cur_bank,
    output logic [SLOT_W-1:0] next_slot,
    output logic [1:0]        next_bank
);

    typedef struct packed {
        logic [SLOT_W-1:0] cnt;
        logic [1:0]        bank;
    } tb_state_t;

    tb_state_t st_d, st_q;
    logic      last_slot;

    always_comb begin
        st_d      = st_q;
        cur_slot  = frame_pulse ? '0 : st_q.cnt;
        // a new frame starts whenever the slot number is 0
        cur_bank  = (cur_slot == '0) ? bank_next(st_q.bank) : st_q.bank;
        last_slot = (cur_slot == SLOT_W'(NUM_SLOTS - 1));
        next_slot = last_slot ? '0 : cur_slot + 1'b1;
        next_bank = last_slot ? bank_next(cur_bank) : cur_bank;
        st_d.cnt  = next_slot;
        st_d.bank = cur_bank;
    end

    always_ff @(posedge clk) begin
        if (rst) begin
            st_q.cnt  <= '0;
            st_q.bank <= 2'd2;
        end else begin
            st_q <= st_d;
        end
    end

endmodule

// File: rtl/tsi_route.sv
module tsi_route
    import tsi_pkg::*;
#(
    parameter int NUM_SLOTS   = 32,
    parameter int NUM_STREAMS = 2,
    localparam int SLOT_W  = $clog2(NUM_SLOTS),
    localparam int STRM_W  = (NUM_STREAMS > 1) ? $clog2(NUM_STREAMS) : 1,
    localparam int ENTRY_W = SLOT_W + STRM_W + 1
) (
    input  logic [ENTRY_W-1:0] entry,
    input  logic [SLOT_W-1:0]  out_slot,
    output logic [SLOT_W-1:0]  src_slot,
    output logic [STRM_W-1:0]  src_stream,
    output age_e               age
);

    int t_i;
    int s_i;

    always_comb begin
        src_slot   = entry[SLOT_W-1:0];
        src_stream = entry[SLOT_W +: STRM_W];
        t_i        = int'(out_slot);
        s_i        = int'(entry[SLOT_W-1:0]);
        if (entry[ENTRY_W-1]) begin
            age = AGE_TWO;
        end else if (t_i >= s_i + 3) begin
            age = AGE_SAME;
        end else if (t_i + NUM_SLOTS >= s_i + 3) begin
            age = AGE_ONE;
        end else begin
            age = AGE_TWO;
        end
    end

endmodule

// File: rtl/tsi_data_mem.sv
module tsi_data_mem
    import tsi_pkg::*;
#(
    parameter int NUM_SLOTS   = 32,
    parameter int NUM_STREAMS = 2,
    parameter int DATA_W      = 8,
    localparam int SLOT_W = $clog2(NUM_SLOTS),
    localparam int STRM_W = (NUM_STREAMS > 1) ? $clog2(NUM_STREAMS) : 1,
    localparam int DEPTH  = N_BANKS * NUM_STREAMS * NUM_SLOTS,
    localparam int ADDR_W = $clog2(DEPTH)
) (
    input  logic                          clk,
    input  logic                          rst,
    input  logic [1:0]                    wr_bank,
    input  logic [SLOT_W-1:0]             wr_slot,
    input  logic [NUM_STREAMS*DATA_W-1:0] wr_data,
    input  logic [NUM_STREAMS*2-1:0]      rd_bank,
    input  logic [NUM_STREAMS*STRM_W-1:0] rd_stream,
    input  logic [NUM_STREAMS*SLOT_W-1:0] rd_slot,
    output logic [NUM_STREAMS*DATA_W-1:0] rd_data
);

    logic [DATA_W-1:0] mem_d [DEPTH];
    logic [DATA_W-1:0] mem_q [DEPTH];

    function automatic logic [ADDR_W-1:0] addr_of(input int bank, input int strm, input int slot);
        return ADDR_W'((bank * NUM_STREAMS + strm) * NUM_SLOTS + slot);
    endfunction

    always_comb begin
        mem_d = mem_q;
        for (int st = 0; st < NUM_STREAMS; st++) begin
            mem_d[addr_of(int'(wr_bank), st, int'(wr_slot))] = wr_data[st*DATA_W +: DATA_W];
        end
    end

    always_comb begin
        for (int i = 0; i < NUM_STREAMS; i++) begin
            if (int'(rd_stream[i*STRM_W +: STRM_W]) < NUM_STREAMS) begin
                rd_data[i*DATA_W +: DATA_W] =
                    mem_q[addr_of(int'(rd_bank[i*2 +: 2]),
                                  int'(rd_stream[i*STRM_W +: STRM_W]),
                                  int'(rd_slot[i*SLOT_W +: SLOT_W]))];
            end else begin
                rd_data[i*DATA_W +: DATA_W] = '0;
            end
        end
    end

    always_ff @(posedge clk) begin
        if (rst) begin
            for (int i = 0; i < DEPTH; i++) mem_q[i] <= '0;
        end else begin
            mem_q <= mem_d;
        end
    end

endmodule

// File: rtl/tsi_switch.sv
module tsi_switch
    import tsi_pkg::*;
#(
    parameter int NUM_SLOTS   = 32,
    parameter int NUM_STREAMS = 2,
    parameter int DATA_W      = 8,
    localparam int SLOT_W  = $clog2(NUM_SLOTS),
    localparam int STRM_W  = (NUM_STREAMS > 1) ? $clog2(NUM_STREAMS) : 1,
    localparam int ENTRY_W = SLOT_W + STRM_W + 1
) (
    input  logic                           clk,
    input  logic                           rst,
    input  logic                           frame_pulse,
    input  logic [NUM_STREAMS*DATA_W-1:0]  rx_data,
    output logic [SLOT_W-1:0]              slot_o,
    output logic [SLOT_W-1:0]              cm_slot,
    input  logic [NUM_STREAMS*ENTRY_W-1:0] cm_entry,
    output logic [NUM_STREAMS*DATA_W-1:0]  tx_data
);

    logic [SLOT_W-1:0]             cur_slot;
    logic [SLOT_W-1:0]             next_slot;
    logic [1:0]                    cur_bank;
    logic [1:0]                    next_bank;
    logic [NUM_STREAMS*2-1:0]      rd_bank;
    logic [NUM_STREAMS*STRM_W-1:0] rd_stream;
    logic [NUM_STREAMS*SLOT_W-1:0] rd_slot;
    logic [NUM_STREAMS*DATA_W-1:0] rd_data;
    logic [NUM_STREAMS*2-1:0]      age_vec;
    logic [NUM_STREAMS*DATA_W-1:0] tx_d, tx_q;

    tsi_timebase #(.NUM_SLOTS(NUM_SLOTS)) i_timebase (
        .clk         (clk),
        .rst         (rst),
        .frame_pulse (frame_pulse),
        .cur_slot    (cur_slot),
        .cur_bank    (cur_bank),
        .next_slot   (next_slot),
        .next_bank   (next_bank)
    );

    for (genvar g = 0; g < NUM_STREAMS; g++) begin : g_route
        age_e age_g;

        tsi_route #(.NUM_SLOTS(NUM_SLOTS), .NUM_STREAMS(NUM_STREAMS)) i_route (
            .entry      (cm_entry[g*ENTRY_W +: ENTRY_W]),
            .out_slot   (next_slot),
            .src_slot   (rd_slot[g*SLOT_W +: SLOT_W]),
            .src_stream (rd_stream[g*STRM_W +: STRM_W]),
            .age        (age_g)
        );

        assign rd_bank[g*2 +: 2] = bank_back(next_bank, age_g);
        assign age_vec[g*2 +: 2] = age_g;
    end

    tsi_data_mem #(
        .NUM_SLOTS   (NUM_SLOTS),
        .NUM_STREAMS (NUM_STREAMS),
        .DATA_W      (DATA_W)
    ) i_data_mem (
        .clk       (clk),
        .rst       (rst),
        .wr_bank   (cur_bank),
        .wr_slot   (cur_slot),
        .wr_data   (rx_data),
        .rd_bank   (rd_bank),
        .rd_stream (rd_stream),
        .rd_slot   (rd_slot),
        .rd_data   (rd_data)
    );

    always_comb begin
        tx_d = rd_data;
    end

    always_ff @(posedge clk) begin
        if (rst) tx_q <= '0;
        else     tx_q <= tx_d;
    end

    assign slot_o  = cur_slot;
    assign cm_slot = next_slot;
    assign tx_data = tx_q;

endmodule

// File: rtl/tsi_switch_chk.sv
module tsi_switch_chk #(
    parameter int NUM_SLOTS   = 32,
    parameter int NUM_STREAMS = 2,
    localparam int SLOT_W  = $clog2(NUM_SLOTS),
    localparam int STRM_W  = (NUM_STREAMS > 1) ? $clog2(NUM_STREAMS) : 1,
    localparam int ENTRY_W = SLOT_W + STRM_W + 1
) (
    input logic                           clk,
    input logic                           rst,
    input logic                           frame_pulse,
    input logic [SLOT_W-1:0]              slot_o,
    input logic [SLOT_W-1:0]              cm_slot,
    input logic [NUM_STREAMS*ENTRY_W-1:0] cm_entry,
    input logic [NUM_STREAMS*2-1:0]       age_vec
);

    logic              seen_q;
    logic [SLOT_W-1:0] succ_slot;

    always_ff @(posedge clk) begin
        if (rst) seen_q <= 1'b0;
        else     seen_q <= 1'b1;
    end

    always_comb begin
        succ_slot = (slot_o == SLOT_W'(NUM_SLOTS - 1)) ? '0 : slot_o + 1'b1;
    end

    assert_pulse_slot0_R1: assert property (@(posedge clk) disable iff (rst)
        frame_pulse |-> slot_o == '0)
        else $error("slot not zero on frame pulse");

    assert_slot_advance_R1: assert property (@(posedge clk) disable iff (rst)
        (seen_q && !frame_pulse) |-> slot_o == $past(succ_slot))
        else $error("slot count did not advance");

    assert_lookup_ahead_R9: assert property (@(posedge clk) disable iff (rst)
        cm_slot == succ_slot)
        else $error("lookup slot is not one ahead");

    for (genvar g = 0; g < NUM_STREAMS; g++) begin : g_chk
        logic       ent_const;
        logic [1:0] ag;
        int         s_i;
        int         t_i;

        always_comb begin
            ent_const = cm_entry[g*ENTRY_W + ENTRY_W - 1];
            ag        = age_vec[g*2 +: 2];
            s_i       = int'(cm_entry[g*ENTRY_W +: SLOT_W]);
            t_i       = int'(cm_slot);
        end

        assert_const_two_back_R5: assert property (@(posedge clk) disable iff (rst)
            ent_const |-> ag == 2'd2)
            else $error("integrity slot not read two frames back");

        assert_var_same_frame_R2: assert property (@(posedge clk) disable iff (rst)
            (!ent_const && t_i >= s_i + 3) |-> ag == 2'd0)
            else $error("latency slot not read from current frame");

        assert_var_next_frame_R3: assert property (@(posedge clk) disable iff (rst)
            (!ent_const && t_i < s_i + 3 && t_i + NUM_SLOTS >= s_i + 3) |-> ag == 2'd1)
            else $error("latency slot not read from previous frame");

        assert_var_min_delay_R4: assert property (@(posedge clk) disable iff (rst)
            (!ent_const && t_i + NUM_SLOTS < s_i + 3) |-> ag == 2'd2)
            else $error("latency slot would break minimum delay");
    end

endmodule

bind tsi_switch tsi_switch_chk #(
    .NUM_SLOTS   (NUM_SLOTS),
    .NUM_STREAMS (NUM_STREAMS)
) i_tsi_switch_chk (
    .clk         (clk),
    .rst         (rst),
    .frame_pulse (frame_pulse),
    .slot_o      (slot_o),
    .cm_slot     (cm_slot),
    .cm_entry    (cm_entry),
    .age_vec     (age_vec)
);

// File: tb/test_tsi_switch.sv
module test_tsi_switch;

    localparam int N      = 32;
    localparam int S      = 2;
    localparam int W      = 8;
    localparam int SLOT_W = 5;
    localparam int E_W    = 7;
    localparam int PHASE_LEN = 2 * N;
    localparam int N_PHASES  = 70;

    logic             clk = 1'b0;
    logic             rst;
    logic             frame_pulse;
    logic [S*W-1:0]   rx_data;
    logic [SLOT_W-1:0] slot_o;
    logic [SLOT_W-1:0] cm_slot;
    logic [S*E_W-1:0] cm_entry;
    logic [S*W-1:0]   tx_data;

    logic [E_W-1:0] cfg [S][N];
    logic [W-1:0]   hist [256][S];
    logic [W-1:0]   exp_val [S];
    string          exp_tag [S];
    int             n_tests = 0;
    int             n_fail  = 0;
    int             kind_now = 0;
    bit             done = 1'b0;

    always #5 clk = ~clk;

    tsi_switch i_tsi_switch (
        .clk         (clk),
        .rst         (rst),
        .frame_pulse (frame_pulse),
        .rx_data     (rx_data),
        .slot_o      (slot_o),
        .cm_slot     (cm_slot),
        .cm_entry    (cm_entry),
        .tx_data     (tx_data)
    );

    // connection memory model: combinational read
    always_comb begin
        for (int o = 0; o < S; o++) cm_entry[o*E_W +: E_W] = cfg[o][cm_slot];
    end

    task automatic chk(input string req, input logic [31:0] act, input logic [31:0] expv);
        n_tests++;
        if (act !== expv) begin
            n_fail++;
            $display("FAIL %s actual %0h expected %0h at %0t", req, act, expv, $time);
        end
    endtask

    // kind 0: latency, crossed stream; 1: integrity, crossed; 2: mixed, same stream; 3: latency, same stream
    task automatic set_phase(input int kind, input int p);
        kind_now = kind;
        for (int o = 0; o < S; o++) begin
            for (int t = 0; t < N; t++) begin
                logic md;
                logic st;
                logic [4:0] src;
                src = 5'((t + p) % N);
                st  = (kind >= 2) ? 1'(o) : 1'(o ^ 1);
                md  = (kind == 1) ? 1'b1 : (kind == 2) ? 1'(t & 1) : 1'b0;
                cfg[o][t] = {md, st, src};
            end
        end
    endtask

    task automatic predict(input int tn);
        for (int o = 0; o < S; o++) begin
            int t, s, d, srct;
            logic [E_W-1:0] e;
            string cat;
            t = tn % N;
            e = cfg[o][t];
            s = int'(e[4:0]);
            if (e[6]) begin
                d   = 2 * N + t - s;
                cat = "R5";
            end else begin
                d = ((((t - s - 3) % N) + N) % N) + 3;
                if (t >= s + 3)          cat = "R2";
                else if (t + N >= s + 3) cat = "R3";
                else                     cat = "R4";
            end
            cat = {cat, (kind_now == 2) ? " R6" : " R7"};
            srct = tn - d;
            if (srct < 0) begin
                exp_val[o] = '0;
                exp_tag[o] = {"R8 ", cat};
            end else begin
                exp_val[o] = hist[srct % 256][int'(e[5])];
                exp_tag[o] = cat;
            end
        end
    endtask

    task automatic summary;
        if (!done) begin
            done = 1'b1;
            $display("[TB] %0d tests run, %0d failed", n_tests, n_fail);
        end
    endtask

    initial begin
        repeat (100000) @(posedge clk);
        n_tests++;
        n_fail++;
        $display("FAIL watchdog expired");
        summary();
        $finish;
    end

    initial begin
        rst         = 1'b1;
        frame_pulse = 1'b0;
        rx_data     = '0;
        set_phase(0, 0);
        repeat (3) @(posedge clk);
        @(negedge clk);
        #1;
        chk("R8 tx in reset", 32'(tx_data), 32'd0);
        chk("R8 slot in reset", 32'(slot_o), 32'd0);
        for (int o = 0; o < S; o++) begin
            exp_val[o] = '0;
            exp_tag[o] = "R8";
        end
        rst = 1'b0;
        for (int tn = 0; tn < N_PHASES * PHASE_LEN; tn++) begin
            if (tn != 0) @(negedge clk);
            if (tn % PHASE_LEN == 0) begin
                int ph;
                ph = tn / PHASE_LEN;
                if (ph < 32)      set_phase(0, ph);
                else if (ph < 64) set_phase(1, ph - 32);
                else if (ph < 68) set_phase(2, (ph - 64) * 9);
                else              set_phase(3, ph - 68);
            end
            frame_pulse = (tn % N == 0);
            for (int st = 0; st < S; st++) begin
                logic [W-1:0] tagv;
                tagv = {1'(st), 7'(tn)} ^ 8'h55;
                rx_data[st*W +: W] = tagv;
                hist[tn % 256][st] = tagv;
            end
            #1;
            chk("R1 slot count", 32'(slot_o), 32'(tn % N));
            chk("R9 lookup slot", 32'(cm_slot), 32'((tn + 1) % N));
            for (int o = 0; o < S; o++) begin
                chk(exp_tag[o], 32'(tx_data[o*W +: W]), 32'(exp_val[o]));
            end
            predict(tn + 1);
        end
        summary();
        $finish;
    end

endmodule